// File: doc/BRIEF.md
# Condition Evaluation and Branch/Move Resolver

This block decides whether a 4-bit condition code is satisfied by the current status flags. The flags are zero, sign, overflow, carry and saturate. The block then acts on that decision in two ways. The branch side builds a signed, halfword-aligned displacement from two separate instruction fields and resolves the next program counter. The move side picks one of two 32-bit operands. The first operand is either a register value or a small signed immediate.

A decode stage presents the current instruction address, the condition field, both displacement fields, the move operands and the live flags each cycle. One clock edge later the block returns the next PC, the move result and a trap request. A branch on the "always" condition whose displacement fields are both zero would loop on itself forever. The block does not take that branch and raises the trap request instead.

Top module: `cond_branch_unit`

## Requirements
- R1: Codes 0 to 7 hold when, in order: OV=1; CY=1; Z=1; (CY|Z)=1; S=1; always; (S^OV)=1; ((S^OV)|Z)=1.
- R2: Each code 8 to 15 other than 13 holds exactly when the code 8 below it does not hold. Code 13 (0xD) holds when the saturate flag is 1.
- R3: The displacement has bits [8:4] equal to the 5-bit upper field, bits [3:1] equal to the 3-bit lower field and bit 0 equal to 0. It is sign-extended from bit 8, so its range is -256 to +254.
- R4: When the condition holds and no trap is raised, the next PC is the current PC plus the displacement, modulo 2^32.
- R5: When the condition does not hold, the next PC is the current PC plus 2, modulo 2^32.
- R6: Code 5 with both displacement fields zero raises the trap request and makes the next PC equal to the current PC. Every other input pattern leaves the trap request low.
- R7: The move result is operand A when the condition holds and operand B otherwise. This includes the cycle in which a trap is raised.
- R8: When the immediate select is 1, operand A is the 5-bit immediate sign-extended from its bit 4 to 32 bits. When the select is 0, operand A is the register operand.
- R9: All three outputs are registered. They reflect the inputs present at the previous rising clock edge.
- R10: A synchronous active-high reset clears the trap request, the next PC and the move result to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| cond_i | input | 4 | Condition code |
| disp_hi_i | input | 5 | Upper displacement field |
| disp_lo_i | input | 3 | Lower displacement field |
| flg_z_i | input | 1 | Zero flag |
| flg_s_i | input | 1 | Sign flag |
| flg_ov_i | input | 1 | Overflow flag |
| flg_cy_i | input | 1 | Carry flag |
| flg_sat_i | input | 1 | Saturate flag |
| opa_reg_i | input | 32 | Register source for operand A |
| opa_imm_i | input | 5 | Immediate source for operand A |
| opa_use_imm_i | input | 1 | 1 selects the immediate as operand A |
| opb_i | input | 32 | Operand B |
| next_pc_o | output | 32 | Resolved next PC |
| cmov_o | output | 32 | Conditional move result |
| trap_o | output | 1 | Trap request for a branch-always to itself |

## Verification
The trap and the conditional move can fall in the same cycle. Code 5 with zeroed displacement fields is an always-true condition, so the move side must still pass operand A while the branch side raises the trap and holds the PC. The bench drives that pattern with distinct A and B values, using both register and immediate sources for A. It also drives code 5 with only one field nonzero, where the branch must be taken and no trap raised. Each of these cycles is judged on all three outputs at once against values computed by the bench's own functions.

// File: rtl/ccbu_pkg.sv
package ccbu_pkg;

  localparam logic [3:0] CC_ALWAYS = 4'h5;
  localparam logic [3:0] CC_SAT    = 4'hD;

  typedef struct packed {
    logic sat;
    logic ov;
    logic s;
    logic z;
    logic cy;
  } flags_t;

  // base condition for the low three code bits
  function automatic logic cc_base(input logic [2:0] sel, input flags_t f);
    logic r;
    unique case (sel)
      3'd0: r = f.ov;
      3'd1: r = f.cy;
      3'd2: r = f.z;
      3'd3: r = f.cy | f.z;
      3'd4: r = f.s;
      3'd5: r = 1'b1;
      3'd6: r = f.s ^ f.ov;
      default: r = (f.s ^ f.ov) | f.z;
    endcase
    return r;
  endfunction

  // full 16-entry evaluation: upper half inverts, except the saturate code
  function automatic logic cc_holds(input logic [3:0] code, input flags_t f);
    if (code == CC_SAT) return f.sat;
    return cc_base(code[2:0], f) ^ code[3];
  endfunction

endpackage

// File: rtl/ccbu_cond_eval.sv
module ccbu_cond_eval
  import ccbu_pkg::*;
(
  input  logic [3:0] code_i,
  input  flags_t     flg_i,
  output logic       holds_o
);
  always_comb holds_o = cc_holds(code_i, flg_i);
endmodule

// File: rtl/ccbu_br_path.sv
module ccbu_br_path
  import ccbu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DHI_W      = 5,
  parameter int DLO_W      = 3,
  parameter int INSN_BYTES = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [3:0]        code_i,
  input  logic [DHI_W-1:0]  hi_i,
  input  logic [DLO_W-1:0]  lo_i,
  input  logic              holds_i,
  output logic [ADDR_W-1:0] disp_o,
  output logic              trap_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  localparam int DISP_W = DHI_W + DLO_W + 1;

  logic [DISP_W-1:0] raw;

  always_comb begin
    raw     = {hi_i, lo_i, 1'b0};
    disp_o  = {{(ADDR_W-DISP_W){raw[DISP_W-1]}}, raw};
    trap_o  = (code_i == CC_ALWAYS) && (hi_i == '0) && (lo_i == '0);
    taken_o = holds_i && !trap_o;
    if (trap_o)       next_pc_o = pc_i;
    else if (taken_o) next_pc_o = pc_i + disp_o;
    else              next_pc_o = pc_i + ADDR_W'(INSN_BYTES);
  end
endmodule

// File: rtl/ccbu_mov_path.sv
module ccbu_mov_path #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic [DATA_W-1:0] reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              holds_i,
  output logic [DATA_W-1:0] opa_o,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    opa_o = use_imm_i ? {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : reg_i;
    res_o = holds_i ? opa_o : opb_i;
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import ccbu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DHI_W      = 5,
  parameter int DLO_W      = 3,
  parameter int IMM_W      = 5,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [3:0]        cond_i,
  input  logic [DHI_W-1:0]  disp_hi_i,
  input  logic [DLO_W-1:0]  disp_lo_i,
  input  logic              flg_z_i,
  input  logic              flg_s_i,
  input  logic              flg_ov_i,
  input  logic              flg_cy_i,
  input  logic              flg_sat_i,
  input  logic [DATA_W-1:0] opa_reg_i,
  input  logic [IMM_W-1:0]  opa_imm_i,
  input  logic              opa_use_imm_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic [DATA_W-1:0] cmov_o,
  output logic              trap_o
);
  flags_t            flags_w;
  logic              holds_w, trap_w, taken_w;
  logic [ADDR_W-1:0] disp_w, npc_w;
  logic [DATA_W-1:0] opa_w, mov_w;

  assign flags_w = '{sat: flg_sat_i, ov: flg_ov_i, s: flg_s_i, z: flg_z_i, cy: flg_cy_i};

  ccbu_cond_eval u_eval (.code_i(cond_i), .flg_i(flags_w), .holds_o(holds_w));

  ccbu_br_path #(.ADDR_W(ADDR_W), .DHI_W(DHI_W), .DLO_W(DLO_W), .INSN_BYTES(INSN_BYTES)) u_br (
    .pc_i(pc_i), .code_i(cond_i), .hi_i(disp_hi_i), .lo_i(disp_lo_i), .holds_i(holds_w),
    .disp_o(disp_w), .trap_o(trap_w), .taken_o(taken_w), .next_pc_o(npc_w)
  );

  ccbu_mov_path #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_mov (
    .reg_i(opa_reg_i), .imm_i(opa_imm_i), .use_imm_i(opa_use_imm_i), .opb_i(opb_i),
    .holds_i(holds_w), .opa_o(opa_w), .res_o(mov_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o <= '0;
      cmov_o    <= '0;
      trap_o    <= 1'b0;
    end else begin
      next_pc_o <= npc_w;
      cmov_o    <= mov_w;
      trap_o    <= trap_w;
    end
  end

  // R1: the always code is satisfied whatever the flags are
  a_r1_always_holds: assert property (@(posedge clk) disable iff (rst)
    (cond_i == CC_ALWAYS) |-> holds_w);

  // R4: a taken branch lands on pc plus the rebuilt displacement
  a_r4_taken_target: assert property (@(posedge clk) disable iff (rst)
    taken_w |=> (next_pc_o == $past(pc_i + disp_w)));

  // R5: a failed condition falls through by one instruction
  a_r5_fall_through: assert property (@(posedge clk) disable iff (rst)
    !holds_w |=> (next_pc_o == $past(pc_i) + ADDR_W'(INSN_BYTES)) && !trap_o);

  // R6: a self-branch traps and holds the PC
  a_r6_trap_holds_pc: assert property (@(posedge clk) disable iff (rst)
    trap_w |=> trap_o && (next_pc_o == $past(pc_i)));

  // R7: the move picks operand A whenever the condition holds
  a_r7_move_picks_a: assert property (@(posedge clk) disable iff (rst)
    holds_w |=> (cmov_o == $past(opa_w)));

  // R10: reset clears all outputs
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> !trap_o && (next_pc_o == '0) && (cmov_o == '0));
endmodule

// File: tb/tb_cond_branch_unit.sv
module tb_cond_branch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0;
  logic [3:0]  cond_i = '0;
  logic [4:0]  disp_hi_i = '0;
  logic [2:0]  disp_lo_i = '0;
  logic        flg_z_i = 0, flg_s_i = 0, flg_ov_i = 0, flg_cy_i = 0, flg_sat_i = 0;
  logic [31:0] opa_reg_i = '0;
  logic [4:0]  opa_imm_i = '0;
  logic        opa_use_imm_i = 0;
  logic [31:0] opb_i = '0;
  logic [31:0] next_pc_o, cmov_o;
  logic        trap_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cond_branch_unit dut (.*);

  function automatic bit ref_cond(input logic [3:0] c, input bit z, s, ov, cy, sat);
    case (c)
      4'h0: return ov;          4'h8: return !ov;
      4'h1: return cy;          4'h9: return !cy;
      4'h2: return z;           4'hA: return !z;
      4'h3: return cy || z;     4'hB: return !(cy || z);
      4'h4: return s;           4'hC: return !s;
      4'h5: return 1;           4'hD: return sat;
      4'h6: return s != ov;     4'hE: return s == ov;
      default: return (c == 4'h7) ? ((s != ov) || z) : !((s != ov) || z);
    endcase
  endfunction

  function automatic int ref_disp(input logic [4:0] hi, input logic [2:0] lo);
    int d = int'(hi) * 16 + int'(lo) * 2;
    return (d >= 256) ? d - 512 : d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one instruction at a negedge, compare at the next negedge (one register stage)
  task automatic run_one(input string tag);
    bit h, tr;
    logic [31:0] a, enp, emv;
    h  = ref_cond(cond_i, flg_z_i, flg_s_i, flg_ov_i, flg_cy_i, flg_sat_i);
    tr = (cond_i == 4'h5) && (disp_hi_i == 0) && (disp_lo_i == 0);
    a  = opa_use_imm_i ? 32'(signed'(opa_imm_i)) : opa_reg_i;
    if (tr)     enp = pc_i;
    else if (h) enp = pc_i + 32'(ref_disp(disp_hi_i, disp_lo_i));
    else        enp = pc_i + 32'd2;
    emv = h ? a : opb_i;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R6 trap"}, {31'd0, trap_o}, {31'd0, tr});
    check({tag, " R4/R5 next_pc"}, next_pc_o, enp);
    check({tag, " R7/R8 cmov"}, cmov_o, emv);
  endtask

  task automatic set_flags(input logic [4:0] f);
    {flg_sat_i, flg_ov_i, flg_s_i, flg_z_i, flg_cy_i} = f;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R10: reset state, outputs cleared even though inputs are busy
    pc_i = 32'h1000; cond_i = 4'h5;
    @(posedge clk); @(negedge clk);
    check("R10 trap", {31'd0, trap_o}, 32'd0);
    check("R10 next_pc", next_pc_o, 32'd0);
    check("R10 cmov", cmov_o, 32'd0);
    rst = 1'b0;

    // R1/R2: every code against every flag combination
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        cond_i = 4'(c); set_flags(5'(f));
        pc_i = 32'h2000; disp_hi_i = 5'h01; disp_lo_i = 3'h1;
        opa_use_imm_i = 0; opa_reg_i = 32'hAAAA_0000 + 32'(c); opb_i = 32'h5555_0000 + 32'(f);
        run_one("R1/R2 code sweep");
      end
    end

    // R3: most negative and most positive displacements
    cond_i = 4'h5; pc_i = 32'h0000_0100; disp_hi_i = 5'h10; disp_lo_i = 3'h0;
    run_one("R3 min disp");
    check("R3 min disp value", next_pc_o, 32'h0000_0000);
    disp_hi_i = 5'h0F; disp_lo_i = 3'h7;
    run_one("R3 max disp");
    check("R3 max disp value", next_pc_o, 32'h0000_01FE);
    // R4: wrap around the address space
    pc_i = 32'hFFFF_FFF0; disp_hi_i = 5'h02; disp_lo_i = 3'h0;
    run_one("R4 wrap");
    // R5: fall through at the top of memory
    cond_i = 4'h8; set_flags(5'b01000); pc_i = 32'hFFFF_FFFE;
    run_one("R5 wrap");

    // R6 with R7 in the same cycle: trap plus the move from register and from immediate
    cond_i = 4'h5; disp_hi_i = 0; disp_lo_i = 0; pc_i = 32'h0000_4444;
    opa_use_imm_i = 0; opa_reg_i = 32'h1234_5678; opb_i = 32'h8765_4321;
    run_one("R6+R7 trap reg");
    opa_use_imm_i = 1; opa_imm_i = 5'h10;
    run_one("R6+R8 trap imm");
    check("R8 imm sext", cmov_o, 32'hFFFF_FFF0);
    // R6: only one field nonzero, so the branch is taken and no trap is raised
    opa_use_imm_i = 0; disp_lo_i = 3'h1; run_one("R6 lo only");
    disp_lo_i = 0; disp_hi_i = 5'h01; run_one("R6 hi only");
    // R6: zero fields with a different code do not trap
    cond_i = 4'hD; disp_hi_i = 0; set_flags(5'b10000); run_one("R6 sat code");

    // R8: positive immediate
    cond_i = 4'h2; set_flags(5'b00010); opa_use_imm_i = 1; opa_imm_i = 5'h0F;
    run_one("R8 imm pos");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      cond_i = 4'($urandom_range(0, 15));
      set_flags(5'($urandom));
      pc_i = {$urandom} & 32'hFFFF_FFFE;
      disp_hi_i = 5'($urandom); disp_lo_i = 3'($urandom);
      if ($urandom_range(0, 7) == 0) begin cond_i = 4'h5; disp_hi_i = 0; disp_lo_i = 0; end
      opa_reg_i = $urandom; opa_imm_i = 5'($urandom); opa_use_imm_i = 1'($urandom);
      opb_i = $urandom;
      run_one("R9 random");
    end

    // R10: reset in mid-run clears a pending trap
    cond_i = 4'h5; disp_hi_i = 0; disp_lo_i = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10 mid reset trap", {31'd0, trap_o}, 32'd0);
    check("R10 mid reset pc", next_pc_o, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule